// File: doc/BRIEF.md
# Directory-Protocol Cache Node Controller

This block is the coherence controller of one processor cache in a system with no shared bus. Each cache line is in one of three states: Invalid, Shared (readable) or Exclusive (readable, writable and dirty). Each line also holds a tag and one data word, so a block is one word. The controller never broadcasts anything. On a processor miss it sends a typed request to the home directory of the block. That request carries the node's processor number and the block address. When the home asks for data back or for a copy to be dropped, the controller answers with a typed write-back message. The home and the network are outside the block. They exchange messages with it over one outgoing channel with a valid/ready handshake and one incoming channel with a ready signal.

The processor issues one access at a time. It holds `cpu_req` and its operands steady until `cpu_done` pulses, and it drops `cpu_req` in the cycle after that pulse. The controller walks through five named states:

- **IDLE**: takes requests and serves home messages.
- **EVICT**: writes back a dirty victim.
- **MISS**: sends the read- or write-miss request.
- **WAIT**: waits for the home's data reply and still serves invalidate and fetch messages in the meantime.
- **SNOOP**: sends the write-back that a fetch or fetch/invalidate asks for, then returns to IDLE or WAIT.

The transitions are:

- IDLE to EVICT on a miss whose victim is Exclusive.
- IDLE to MISS on any other miss.
- EVICT to MISS, MISS to WAIT, and SNOOP back to its return state, each when the outgoing message is taken.
- WAIT to IDLE when the data reply arrives.
- IDLE or WAIT to SNOOP when a fetch hits an Exclusive line.

Top module: `ncc_node_ctrl`

## Requirements
- R1: After reset every line is Invalid, `out_valid` and `cpu_done` are 0 and `in_ready` is 1, so the first read of any address sends a read-miss request.
- R2: A read that misses sends a request with type code 0 (read miss), `out_proc` equal to NODE_ID and `out_addr` equal to the read address. The line is filled from the data reply (incoming type code 5) and becomes Shared, and `cpu_rdata` returns the reply data.
- R3: A read that hits a Shared or Exclusive line completes with the stored word and sends no message.
- R4: A write to an Invalid or Shared line sends a request with type code 1 (write miss) carrying NODE_ID and the address. When the data reply arrives, the line becomes Exclusive and holds the write data, not the reply data.
- R5: A write that hits an Exclusive line updates the word, sends no message and completes.
- R6: An incoming invalidate (type code 2) that matches a Shared line makes it Invalid and produces no outgoing message.
- R7: An incoming fetch (type code 3) that matches an Exclusive line sends a data write-back (type code 6) with the line address and word, and the line becomes Shared. A later read hits, but a later write sends a write miss.
- R8: An incoming fetch/invalidate (type code 4) that matches an Exclusive line sends a data write-back with the line address and word, and the line becomes Invalid.
- R9: A miss whose direct-mapped victim (index = low address bits) is Exclusive with another tag first sends a data write-back of the victim address and word. The miss request is the very next outgoing message. A Shared victim is dropped without any message.
- R10: An invalidate, fetch or fetch/invalidate whose line is Invalid, holds another tag, or (for fetch types) is not Exclusive, is accepted with no outgoing message and no state change.
- R11: While `out_valid` is high and `out_ready` is low, the message type, processor number, address and data stay unchanged. `in_ready` stays low while a message is being offered.
- R12: Outgoing messages only use the type codes 0, 1 and 6. Codes 0 and 1 always carry NODE_ID in `out_proc`.
- R13: The processor stalls: `cpu_done` is a single-cycle pulse, never high while a message is being offered, and for a miss it only comes after the data reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Network takes the outgoing message |
| out_type | output | 3 | Outgoing message type code |
| out_proc | output | PROC_W | Requesting processor number |
| out_addr | output | ADDR_W | Block address of the message |
| out_data | output | DATA_W | Write-back data (0 for requests) |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Controller accepts an incoming message |
| in_type | input | 3 | Incoming message type code |
| in_addr | input | ADDR_W | Block address of the incoming message |
| in_data | input | DATA_W | Reply data |

## Verification
The assertions watch, on every cycle, the parts of the behaviour that can be seen on the message channels alone:
- held message fields under back-pressure, and no incoming acceptance while a message is offered;
- the allowed outgoing type codes and the processor number carried by requests;
- the single-cycle, never-during-send completion pulse;
- the rule that an eviction write-back is immediately followed by a miss request.

The line-state effects can only be shown by the directed scenarios, because they appear only in later traffic. These include Shared versus Exclusive after a fill, the downgrade after a fetch, the drop after an invalidate or fetch/invalidate, the silent handling of non-matching home messages, and the priority of write data over reply data.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

    typedef enum logic [2:0] {
        MSG_RD_MISS   = 3'd0,
        MSG_WR_MISS   = 3'd1,
        MSG_INVAL     = 3'd2,
        MSG_FETCH     = 3'd3,
        MSG_FETCH_INV = 3'd4,
        MSG_REPLY     = 3'd5,
        MSG_WB        = 3'd6
    } msg_e;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EVICT = 3'd1,
        ST_MISS  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_SNOOP = 3'd4
    } fsm_e;

endpackage

// File: rtl/ncc_line_array.sv
module ncc_line_array
    import ncc_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_e             a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_e             b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_e             wr_state,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        line_e             st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t entries [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        entry_t ent_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '{st: LN_INV, tag: '0, data: '0};
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_q <= '{st: wr_state, tag: wr_tag, data: wr_data};
            end
        end

        assign entries[g] = ent_q;
    end

    assign a_state = entries[a_idx].st;
    assign a_tag   = entries[a_idx].tag;
    assign a_data  = entries[a_idx].data;
    assign b_state = entries[b_idx].st;
    assign b_tag   = entries[b_idx].tag;
    assign b_data  = entries[b_idx].data;

endmodule

// File: rtl/ncc_in_decoder.sv
module ncc_in_decoder
    import ncc_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic [2:0]       in_type,
    input  logic [TAG_W-1:0] in_tag,
    input  line_e            ln_state,
    input  logic [TAG_W-1:0] ln_tag,
    output logic             dec_inval,
    output logic             dec_fetch,
    output logic             dec_kill,
    output logic             dec_reply
);

    logic match;

    always_comb begin
        match     = (ln_state != LN_INV) && (ln_tag == in_tag);
        dec_inval = 1'b0;
        dec_fetch = 1'b0;
        dec_kill  = 1'b0;
        dec_reply = 1'b0;
        unique case (msg_e'(in_type))
            MSG_INVAL:     dec_inval = match && (ln_state == LN_SHR);
            MSG_FETCH:     dec_fetch = match && (ln_state == LN_EXC);
            MSG_FETCH_INV: begin
                dec_fetch = match && (ln_state == LN_EXC);
                dec_kill  = 1'b1;
            end
            MSG_REPLY:     dec_reply = 1'b1;
            default:       ;
        endcase
    end

endmodule

// File: rtl/ncc_msg_encoder.sv
module ncc_msg_encoder
    import ncc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int PROC_W  = 4,
    parameter int NODE_ID = 3
) (
    input  fsm_e              st,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] vict_addr,
    input  logic [DATA_W-1:0] vict_data,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [DATA_W-1:0] snoop_data,
    output logic              out_valid,
    output logic [2:0]        out_type,
    output logic [PROC_W-1:0] out_proc,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    always_comb begin
        out_valid = 1'b0;
        out_type  = MSG_RD_MISS;
        out_proc  = PROC_W'(NODE_ID);
        out_addr  = '0;
        out_data  = '0;
        unique case (st)
            ST_EVICT: begin
                out_valid = 1'b1;
                out_type  = MSG_WB;
                out_addr  = vict_addr;
                out_data  = vict_data;
            end
            ST_MISS: begin
                out_valid = 1'b1;
                out_type  = req_we ? MSG_WR_MISS : MSG_RD_MISS;
                out_addr  = req_addr;
            end
            ST_SNOOP: begin
                out_valid = 1'b1;
                out_type  = MSG_WB;
                out_addr  = snoop_addr;
                out_data  = snoop_data;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ncc_node_ctrl.sv
module ncc_node_ctrl
    import ncc_pkg::*;
#(
    parameter int LINES   = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int PROC_W  = 4,
    parameter int NODE_ID = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_type,
    output logic [PROC_W-1:0] out_proc,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_type,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    fsm_e state_q, state_d, ret_q, ret_d;
    logic              req_we_q, req_we_d;
    logic [ADDR_W-1:0] req_addr_q, req_addr_d;
    logic [DATA_W-1:0] req_wdata_q, req_wdata_d;
    logic [IDX_W-1:0]  snoop_idx_q, snoop_idx_d;
    logic              snoop_kill_q, snoop_kill_d;
    logic              done_q, done_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;

    logic [IDX_W-1:0]  a_idx, b_idx, wr_idx;
    line_e             a_state, b_state, wr_state;
    logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
    logic [DATA_W-1:0] a_data, b_data, wr_data;
    logic              wr_en;
    logic              dec_inval, dec_fetch, dec_kill, dec_reply;
    logic              a_hit;

    logic [IDX_W-1:0]  cpu_idx, req_idx, in_idx;
    logic [TAG_W-1:0]  cpu_tag, req_tag, in_tag;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx = req_addr_q[IDX_W-1:0];
    assign req_tag = req_addr_q[ADDR_W-1:IDX_W];
    assign in_idx  = in_addr[IDX_W-1:0];
    assign in_tag  = in_addr[ADDR_W-1:IDX_W];

    assign a_idx = (state_q == ST_IDLE) ? cpu_idx : req_idx;
    assign b_idx = (state_q == ST_SNOOP) ? snoop_idx_q : in_idx;
    assign a_hit = (a_state != LN_INV) && (a_tag == cpu_tag);

    ncc_line_array #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state),
        .wr_tag(wr_tag), .wr_data(wr_data)
    );

    ncc_in_decoder #(.TAG_W(TAG_W)) u_dec (
        .in_type(in_type), .in_tag(in_tag),
        .ln_state(b_state), .ln_tag(b_tag),
        .dec_inval(dec_inval), .dec_fetch(dec_fetch),
        .dec_kill(dec_kill), .dec_reply(dec_reply)
    );

    ncc_msg_encoder #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROC_W(PROC_W), .NODE_ID(NODE_ID)
    ) u_enc (
        .st(state_q), .req_we(req_we_q), .req_addr(req_addr_q),
        .vict_addr({a_tag, req_idx}), .vict_data(a_data),
        .snoop_addr({b_tag, snoop_idx_q}), .snoop_data(b_data),
        .out_valid(out_valid), .out_type(out_type), .out_proc(out_proc),
        .out_addr(out_addr), .out_data(out_data)
    );

    // Next-state and line-update logic
    always_comb begin
        state_d      = state_q;
        ret_d        = ret_q;
        req_we_d     = req_we_q;
        req_addr_d   = req_addr_q;
        req_wdata_d  = req_wdata_q;
        snoop_idx_d  = snoop_idx_q;
        snoop_kill_d = snoop_kill_q;
        done_d       = 1'b0;
        rdata_d      = rdata_q;
        wr_en        = 1'b0;
        wr_idx       = a_idx;
        wr_state     = LN_INV;
        wr_tag       = a_tag;
        wr_data      = a_data;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    if (dec_inval) begin
                        wr_en   = 1'b1;
                        wr_idx  = in_idx;
                        wr_tag  = b_tag;
                        wr_data = b_data;
                    end else if (dec_fetch) begin
                        snoop_idx_d  = in_idx;
                        snoop_kill_d = dec_kill;
                        ret_d        = ST_IDLE;
                        state_d      = ST_SNOOP;
                    end
                end else if (cpu_req && !done_q) begin
                    req_we_d    = cpu_we;
                    req_addr_d  = cpu_addr;
                    req_wdata_d = cpu_wdata;
                    if (a_hit && !cpu_we) begin
                        done_d  = 1'b1;
                        rdata_d = a_data;
                    end else if (a_hit && (a_state == LN_EXC)) begin
                        wr_en    = 1'b1;
                        wr_idx   = cpu_idx;
                        wr_state = LN_EXC;
                        wr_data  = cpu_wdata;
                        done_d   = 1'b1;
                        rdata_d  = cpu_wdata;
                    end else if (a_state == LN_EXC) begin
                        state_d = ST_EVICT;
                    end else begin
                        state_d = ST_MISS;
                    end
                end
            end
            ST_EVICT: begin
                if (out_ready) begin
                    wr_en   = 1'b1;
                    wr_idx  = req_idx;
                    state_d = ST_MISS;
                end
            end
            ST_MISS: begin
                if (out_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (in_valid) begin
                    if (dec_reply) begin
                        wr_en    = 1'b1;
                        wr_idx   = req_idx;
                        wr_state = req_we_q ? LN_EXC : LN_SHR;
                        wr_tag   = req_tag;
                        wr_data  = req_we_q ? req_wdata_q : in_data;
                        done_d   = 1'b1;
                        rdata_d  = req_we_q ? req_wdata_q : in_data;
                        state_d  = ST_IDLE;
                    end else if (dec_inval) begin
                        wr_en   = 1'b1;
                        wr_idx  = in_idx;
                        wr_tag  = b_tag;
                        wr_data = b_data;
                    end else if (dec_fetch) begin
                        snoop_idx_d  = in_idx;
                        snoop_kill_d = dec_kill;
                        ret_d        = ST_WAIT;
                        state_d      = ST_SNOOP;
                    end
                end
            end
            ST_SNOOP: begin
                if (out_ready) begin
                    wr_en    = 1'b1;
                    wr_idx   = snoop_idx_q;
                    wr_state = snoop_kill_q ? LN_INV : LN_SHR;
                    wr_tag   = b_tag;
                    wr_data  = b_data;
                    state_d  = ret_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ret_q        <= ST_IDLE;
            req_we_q     <= 1'b0;
            req_addr_q   <= '0;
            req_wdata_q  <= '0;
            snoop_idx_q  <= '0;
            snoop_kill_q <= 1'b0;
            done_q       <= 1'b0;
            rdata_q      <= '0;
        end else begin
            state_q      <= state_d;
            ret_q        <= ret_d;
            req_we_q     <= req_we_d;
            req_addr_q   <= req_addr_d;
            req_wdata_q  <= req_wdata_d;
            snoop_idx_q  <= snoop_idx_d;
            snoop_kill_q <= snoop_kill_d;
            done_q       <= done_d;
            rdata_q      <= rdata_d;
        end
    end

    // Outputs
    always_comb begin
        cpu_done  = done_q;
        cpu_rdata = rdata_q;
        in_ready  = (state_q == ST_IDLE) || (state_q == ST_WAIT);
    end

endmodule

// File: rtl/ncc_checker.sv
module ncc_checker
    import ncc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int PROC_W  = 4,
    parameter int NODE_ID = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [2:0]        out_type,
    input logic [PROC_W-1:0] out_proc,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data,
    input logic              in_ready,
    input logic              cpu_done,
    input logic              evict_phase
);

    a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_type) &&
        $stable(out_proc) && $stable(out_addr) && $stable(out_data));

    a_r11_no_accept_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r12_out_types: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_type == MSG_RD_MISS || out_type == MSG_WR_MISS ||
                       out_type == MSG_WB));

    a_r12_proc_id: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_type == MSG_RD_MISS || out_type == MSG_WR_MISS)
        |-> out_proc == PROC_W'(NODE_ID));

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    a_r13_no_done_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cpu_done);

    a_r9_evict_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && evict_phase |=>
        out_valid && (out_type == MSG_RD_MISS || out_type == MSG_WR_MISS));

endmodule

bind ncc_node_ctrl ncc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROC_W(PROC_W), .NODE_ID(NODE_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_proc(out_proc), .out_addr(out_addr), .out_data(out_data),
    .in_ready(in_ready), .cpu_done(cpu_done),
    .evict_phase(state_q == ncc_pkg::ST_EVICT)
);

// File: tb/tb_ncc_node_ctrl.sv
module tb_ncc_node_ctrl;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int PROC_W = 4;
    localparam int NODE   = 3;

    localparam logic [2:0] T_RD = 3'd0, T_WR = 3'd1, T_INV = 3'd2, T_FET = 3'd3,
                           T_FINV = 3'd4, T_REP = 3'd5, T_WB = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_done;
    logic [DATA_W-1:0] cpu_rdata;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [2:0] out_type;
    logic [PROC_W-1:0] out_proc;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [2:0] in_type = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_data = '0;

    always #5 clk = ~clk;

    ncc_node_ctrl #(.LINES(4), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                    .PROC_W(PROC_W), .NODE_ID(NODE)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_type(out_type), .out_proc(out_proc), .out_addr(out_addr),
        .out_data(out_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_type(in_type), .in_addr(in_addr), .in_data(in_data)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Log of accepted outgoing messages
    logic [2:0]        log_type [0:63];
    logic [ADDR_W-1:0] log_addr [0:63];
    logic [PROC_W-1:0] log_proc [0:63];
    logic [DATA_W-1:0] log_data [0:63];
    int nlog = 0;

    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready && nlog < 64) begin
            log_type[nlog] <= out_type;
            log_addr[nlog] <= out_addr;
            log_proc[nlog] <= out_proc;
            log_data[nlog] <= out_data;
            nlog <= nlog + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    int acc_start;
    logic [DATA_W-1:0] got_rdata;
    bit got_done;

    // One processor access; answers a miss request with a data reply
    task automatic do_access(input logic we, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] reply);
        bit replied = 0;
        got_done = 0;
        @(negedge clk);
        acc_start = nlog;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (cpu_done) begin
                got_done = 1; got_rdata = cpu_rdata;
                break;
            end
            if (!replied && nlog > acc_start &&
                (log_type[nlog-1] == T_RD || log_type[nlog-1] == T_WR)) begin
                in_valid = 1'b1; in_type = T_REP; in_addr = a; in_data = reply;
                replied = 1;
            end
        end
        cpu_req = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic send_home(input logic [2:0] t, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        acc_start = nlog;
        in_valid = 1'b1; in_type = t; in_addr = a; in_data = '0;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 out_valid", out_valid, 0);
        chk("R1 cpu_done", cpu_done, 0);
        chk("R1 in_ready", in_ready, 1);
    endtask

    task automatic t_read_miss_hit();
        do_access(1'b0, 8'h11, '0, 16'hBEEF);
        chk("R1 R2 one message", nlog - acc_start, 1);
        chk("R2 type read miss", log_type[acc_start], T_RD);
        chk("R2 address", log_addr[acc_start], 8'h11);
        chk("R2 R12 proc", log_proc[acc_start], NODE);
        chk("R2 R13 done after reply", got_done, 1);
        chk("R2 rdata", got_rdata, 16'hBEEF);
        do_access(1'b0, 8'h11, '0, 16'h0);
        chk("R3 no message", nlog - acc_start, 0);
        chk("R3 rdata", got_rdata, 16'hBEEF);
    endtask

    task automatic t_write_upgrade();
        do_access(1'b1, 8'h11, 16'h1234, 16'hDEAD);
        chk("R4 one message", nlog - acc_start, 1);
        chk("R4 type write miss", log_type[acc_start], T_WR);
        chk("R4 R12 proc", log_proc[acc_start], NODE);
        chk("R4 address", log_addr[acc_start], 8'h11);
        do_access(1'b1, 8'h11, 16'h5678, 16'h0);
        chk("R5 no message", nlog - acc_start, 0);
        chk("R5 done", got_done, 1);
        do_access(1'b0, 8'h11, '0, 16'h0);
        chk("R5 R4 read back", got_rdata, 16'h5678);
    endtask

    task automatic t_fetch();
        send_home(T_FET, 8'h11);
        chk("R7 one message", nlog - acc_start, 1);
        chk("R7 type write-back", log_type[acc_start], T_WB);
        chk("R7 address", log_addr[acc_start], 8'h11);
        chk("R7 data", log_data[acc_start], 16'h5678);
        do_access(1'b0, 8'h11, '0, 16'h0);
        chk("R7 shared read hit", nlog - acc_start, 0);
        chk("R7 read data", got_rdata, 16'h5678);
        do_access(1'b1, 8'h11, 16'h9ABC, 16'h0);
        chk("R7 shared write misses", log_type[acc_start], T_WR);
    endtask

    task automatic t_fetch_inv();
        send_home(T_FINV, 8'h11);
        chk("R8 one message", nlog - acc_start, 1);
        chk("R8 type write-back", log_type[acc_start], T_WB);
        chk("R8 data", log_data[acc_start], 16'h9ABC);
        do_access(1'b0, 8'h11, '0, 16'h0042);
        chk("R8 invalid after", log_type[acc_start], T_RD);
        chk("R8 rdata", got_rdata, 16'h0042);
    endtask

    task automatic t_invalidate();
        send_home(T_INV, 8'h11);
        chk("R6 no reply", nlog - acc_start, 0);
        do_access(1'b0, 8'h11, '0, 16'h0055);
        chk("R6 read misses", nlog - acc_start, 1);
        chk("R6 type", log_type[acc_start], T_RD);
    endtask

    task automatic t_ignored();
        send_home(T_FINV, 8'h22);
        chk("R10 invalid line", nlog - acc_start, 0);
        send_home(T_FET, 8'h21);
        chk("R10 tag mismatch fetch", nlog - acc_start, 0);
        send_home(T_INV, 8'h21);
        chk("R10 tag mismatch inval", nlog - acc_start, 0);
        send_home(T_FET, 8'h11);
        chk("R10 fetch on shared", nlog - acc_start, 0);
        do_access(1'b0, 8'h11, '0, 16'h0);
        chk("R10 line kept", nlog - acc_start, 0);
        chk("R10 data kept", got_rdata, 16'h0055);
    endtask

    task automatic t_evict();
        do_access(1'b1, 8'h05, 16'h7777, 16'h0);
        chk("R9 shared victim silent", nlog - acc_start, 1);
        chk("R9 write miss", log_type[acc_start], T_WR);
        do_access(1'b0, 8'h09, '0, 16'h0099);
        chk("R9 two messages", nlog - acc_start, 2);
        chk("R9 first is write-back", log_type[acc_start], T_WB);
        chk("R9 victim address", log_addr[acc_start], 8'h05);
        chk("R9 victim data", log_data[acc_start], 16'h7777);
        chk("R9 then read miss", log_type[acc_start+1], T_RD);
        chk("R9 miss address", log_addr[acc_start+1], 8'h09);
        chk("R9 rdata", got_rdata, 16'h0099);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        acc_start = nlog;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h0D; cpu_wdata = 16'h4321;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 valid held", out_valid, 1);
            chk("R11 type held", out_type, T_WR);
            chk("R11 addr held", out_addr, 8'h0D);
            chk("R11 in_ready low", in_ready, 0);
            chk("R13 stalled", cpu_done, 0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R11 taken once", nlog - acc_start, 1);
        chk("R13 no done before reply", cpu_done, 0);
        in_valid = 1'b1; in_type = T_REP; in_addr = 8'h0D; in_data = 16'h1111;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R13 done after reply", cpu_done, 1);
        cpu_req = 1'b0;
        @(negedge clk);
        chk("R13 done pulse", cpu_done, 0);
        do_access(1'b0, 8'h0D, '0, 16'h0);
        chk("R4 write data kept", got_rdata, 16'h4321);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss_hit();
        t_write_upgrade();
        t_fetch();
        t_fetch_inv();
        t_invalidate();
        t_ignored();
        t_evict();
        t_backpressure();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule